// File: doc/BRIEF.md
# Core PLL clock control register

This block is the clock control register that sits between a processor write port and three phase-locked loops. One 11-bit word carries a 6-bit frequency code for the core PLL, two policy bits for that PLL, a frequency select for the second PLL, and power enables for the second and third PLLs. The processor writes the whole word in one cycle and can read it back at any time.

The core frequency code can reach the PLL in two ways. If the update bit is set in the written word, the code takes effect at once. Otherwise the code waits in a shadow buffer. It moves to the PLL only when the synchronized core lock-detect signal falls, which in normal use happens on the exit from deep sleep. Each PLL also has a registered clock-valid output that acts as its gate enable. This output is driven by that PLL's synchronized lock detect. For the core PLL it also follows the chosen mute policy, and for the other two PLLs it also follows their enable bits.

Top module: `pll_clkctl_unit`

## Requirements
- R1: After a synchronous reset, rd_data reads 0x024: the code field holds 0x24 and bits 10:6 are 0. core_code_o is 0x24. code_pending_o, code_illegal_o, every enable output and every clock-valid output are 0.
- R2: A write whose bit 6 is 0 stores bits 5:0 in the shadow buffer only. core_code_o stays unchanged, and code_pending_o goes to 1 when the stored code differs from the applied one.
- R3: A write whose bit 6 is 1 drives bits 5:0 onto core_code_o on the clock edge that takes the write. code_pending_o then reads 0.
- R4: lock_i[0] is synchronized through two flops. When lock_i[0] falls, the shadow code is copied to core_code_o exactly once, three clock edges after the change. No copy happens at two edges.
- R5: While bit 7 is 0, core_clk_en_o follows lock_i[0] three clock edges later, in both directions.
- R6: While bit 7 is 1, core_clk_en_o is 0 from reset until the first synchronized lock. After that it stays 1 through any later loss of lock.
- R7: Bit 8 of the register is driven unchanged onto pll_b_fsel_o.
- R8: Bit 9 drives pll_b_on_o and bit 10 drives pll_c_on_o. The clock-valid output of each of these two PLLs (lock_i[1] and lock_i[2]) is 1 only while its enable bit is 1 and its synchronized lock is 1. While the enable is 0, lock has no effect on that output.
- R9: A code outside 0x24..0x2D is still stored and applied as written. code_illegal_o is 1 while the stored code is outside that range.
- R10: rd_data returns the last written word, including its code field, and not the applied code. code_pending_o is 1 exactly when the stored code and core_code_o differ.
- R11: A rising edge on lock_i[0] does not copy the shadow code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 11 | Word to write |
| rd_data | output | 11 | Processor-visible register value |
| lock_i | input | 3 | Lock detects: [0] core, [1] second, [2] third PLL |
| core_code_o | output | 6 | Code applied to the core PLL |
| core_clk_en_o | output | 1 | Core PLL clock-valid gate enable |
| code_pending_o | output | 1 | Stored code differs from the applied code |
| code_illegal_o | output | 1 | Stored code is outside the legal range |
| pll_b_fsel_o | output | 1 | Second PLL frequency select |
| pll_b_on_o | output | 1 | Second PLL enable |
| pll_c_on_o | output | 1 | Third PLL enable |
| pll_b_clk_en_o | output | 1 | Second PLL clock-valid gate enable |
| pll_c_clk_en_o | output | 1 | Third PLL clock-valid gate enable |

## Verification
The properties assume that the lock inputs are slow level signals that stay stable for several clock cycles, as analog lock detectors do. They also assume that the update bit is judged from the word being written in the same cycle. The bench changes each lock input only at a falling clock edge and holds it for at least three cycles before sampling. It also issues register writes only between lock changes, except where a test deliberately looks at the three-edge window.

// File: rtl/pll_clkctl_pkg.sv
package pll_clkctl_pkg;
  localparam int CODE_W    = 6;
  localparam int REG_W     = CODE_W + 5;
  localparam int NPLL      = 3;
  localparam int BIT_IMM   = CODE_W;
  localparam int BIT_RELAX = CODE_W + 1;
  localparam int BIT_BFSEL = CODE_W + 2;
  localparam int BIT_BON   = CODE_W + 3;
  localparam int BIT_CON   = CODE_W + 4;
  localparam int IDX_CORE  = 0;
  localparam int IDX_B     = 1;
  localparam int IDX_C     = 2;
endpackage

// File: rtl/lock_sync.sv
module lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], async_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign sync_o = sh_q[STAGES-1];
  assign fall_o = prev_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/code_buffer.sv
module code_buffer #(
  parameter int                        CODE_W     = 6,
  parameter logic [CODE_W-1:0]         RESET_CODE = 6'h24,
  parameter logic [CODE_W-1:0]         CODE_MIN   = 6'h24,
  parameter logic [CODE_W-1:0]         CODE_MAX   = 6'h2D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_imm,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              xfer,
  output logic [CODE_W-1:0] shadow_o,
  output logic [CODE_W-1:0] applied_o,
  output logic              pending_o,
  output logic              illegal_o
);
  logic [CODE_W-1:0] shadow_q, applied_q, shadow_d, applied_d;
  logic              pending_q, illegal_q;

  always_comb begin
    shadow_d  = shadow_q;
    applied_d = applied_q;
    if (wr_en) shadow_d = wr_code;
    if (wr_en && wr_imm) applied_d = wr_code;
    else if (xfer)       applied_d = shadow_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q  <= RESET_CODE;
      applied_q <= RESET_CODE;
      pending_q <= 1'b0;
      illegal_q <= (RESET_CODE < CODE_MIN) || (RESET_CODE > CODE_MAX);
    end else begin
      shadow_q  <= shadow_d;
      applied_q <= applied_d;
      pending_q <= (shadow_d != applied_d);
      illegal_q <= (shadow_d < CODE_MIN) || (shadow_d > CODE_MAX);
    end
  end

  assign shadow_o  = shadow_q;
  assign applied_o = applied_q;
  assign pending_o = pending_q;
  assign illegal_o = illegal_q;
endmodule

// File: rtl/clk_gate_ctl.sv
module clk_gate_ctl #(
  parameter int NPLL = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPLL-1:0] lock_s,
  input  logic            relax,
  input  logic [NPLL-1:1] aux_on,
  output logic            core_en_o,
  output logic [NPLL-1:1] aux_en_o,
  output logic            has_locked_o
);
  logic            core_en_q, has_locked_q;
  logic [NPLL-1:1] aux_en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      core_en_q    <= 1'b0;
      has_locked_q <= 1'b0;
    end else begin
      has_locked_q <= has_locked_q | lock_s[0];
      core_en_q    <= relax ? (lock_s[0] | has_locked_q) : lock_s[0];
    end
  end

  for (genvar g = 1; g < NPLL; g++) begin : g_aux
    always_ff @(posedge clk) begin
      if (rst) aux_en_q[g] <= 1'b0;
      else     aux_en_q[g] <= aux_on[g] & lock_s[g];
    end
  end

  assign core_en_o    = core_en_q;
  assign aux_en_o     = aux_en_q;
  assign has_locked_o = has_locked_q;
endmodule

// File: rtl/pll_clkctl_unit.sv
module pll_clkctl_unit
  import pll_clkctl_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [CODE_W-1:0] RESET_CODE  = 6'h24,
  parameter logic [CODE_W-1:0] CODE_MIN    = 6'h24,
  parameter logic [CODE_W-1:0] CODE_MAX    = 6'h2D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic [NPLL-1:0]   lock_i,
  output logic [CODE_W-1:0] core_code_o,
  output logic              core_clk_en_o,
  output logic              code_pending_o,
  output logic              code_illegal_o,
  output logic              pll_b_fsel_o,
  output logic              pll_b_on_o,
  output logic              pll_c_on_o,
  output logic              pll_b_clk_en_o,
  output logic              pll_c_clk_en_o
);
  localparam int CTL_W = REG_W - CODE_W;

  logic [CTL_W-1:0]  ctl_q;
  logic [NPLL-1:0]   lock_s, lock_fall;
  logic [CODE_W-1:0] shadow;
  logic [NPLL-1:1]   aux_on, aux_en;
  logic              xfer, has_locked;

  always_ff @(posedge clk) begin
    if (rst)        ctl_q <= '0;
    else if (wr_en) ctl_q <= wr_data[REG_W-1:CODE_W];
  end

  for (genvar g = 0; g < NPLL; g++) begin : g_sync
    lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .async_i(lock_i[g]),
      .sync_o(lock_s[g]), .fall_o(lock_fall[g])
    );
  end

  assign xfer = lock_fall[IDX_CORE];

  code_buffer #(
    .CODE_W(CODE_W), .RESET_CODE(RESET_CODE),
    .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX)
  ) u_buf (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .wr_imm(wr_data[BIT_IMM]), .wr_code(wr_data[CODE_W-1:0]),
    .xfer(xfer), .shadow_o(shadow), .applied_o(core_code_o),
    .pending_o(code_pending_o), .illegal_o(code_illegal_o)
  );

  assign aux_on[IDX_B] = ctl_q[BIT_BON-CODE_W];
  assign aux_on[IDX_C] = ctl_q[BIT_CON-CODE_W];

  clk_gate_ctl #(.NPLL(NPLL)) u_gate (
    .clk(clk), .rst(rst), .lock_s(lock_s),
    .relax(ctl_q[BIT_RELAX-CODE_W]), .aux_on(aux_on),
    .core_en_o(core_clk_en_o), .aux_en_o(aux_en), .has_locked_o(has_locked)
  );

  assign rd_data        = {ctl_q, shadow};
  assign pll_b_fsel_o   = ctl_q[BIT_BFSEL-CODE_W];
  assign pll_b_on_o     = aux_on[IDX_B];
  assign pll_c_on_o     = aux_on[IDX_C];
  assign pll_b_clk_en_o = aux_en[IDX_B];
  assign pll_c_clk_en_o = aux_en[IDX_C];
endmodule

// File: rtl/pll_clkctl_chk.sv
module pll_clkctl_chk
  import pll_clkctl_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [REG_W-1:0]  wr_data,
  input logic [REG_W-1:0]  rd_data,
  input logic [CODE_W-1:0] core_code_o,
  input logic              code_pending_o,
  input logic              core_clk_en_o,
  input logic              pll_b_on_o,
  input logic              pll_b_clk_en_o,
  input logic [NPLL-1:0]   lock_s,
  input logic              xfer
);
  logic relax;
  assign relax = rd_data[BIT_RELAX];

  p_imm_apply_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[BIT_IMM]) |=> core_code_o == $past(wr_data[CODE_W-1:0]));

  p_defer_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[BIT_IMM] && !xfer) |=> $stable(core_code_o));

  p_strobe_copy_r4: assert property (@(posedge clk) disable iff (rst)
    (xfer && !(wr_en && wr_data[BIT_IMM])) |=> core_code_o == $past(rd_data[CODE_W-1:0]));

  p_strobe_single_r4: assert property (@(posedge clk) disable iff (rst)
    xfer |=> !xfer);

  p_mute_strict_r5: assert property (@(posedge clk) disable iff (rst)
    (!relax && !lock_s[0]) |=> !core_clk_en_o);

  p_relax_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (relax && core_clk_en_o) |=> core_clk_en_o);

  p_aux_gate_r8: assert property (@(posedge clk) disable iff (rst)
    !pll_b_on_o |=> !pll_b_clk_en_o);

  p_pending_r10: assert property (@(posedge clk) disable iff (rst)
    code_pending_o == (rd_data[CODE_W-1:0] != core_code_o));
endmodule

bind pll_clkctl_unit pll_clkctl_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .core_code_o(core_code_o), .code_pending_o(code_pending_o),
  .core_clk_en_o(core_clk_en_o), .pll_b_on_o(pll_b_on_o),
  .pll_b_clk_en_o(pll_b_clk_en_o), .lock_s(lock_s), .xfer(xfer)
);

// File: tb/test_pll_clkctl_unit.sv
`timescale 1ns/1ps
module test_pll_clkctl_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [10:0] wr_data = '0;
  logic [10:0] rd_data;
  logic [2:0]  lock_i = '0;
  logic [5:0]  core_code_o;
  logic        core_clk_en_o, code_pending_o, code_illegal_o;
  logic        pll_b_fsel_o, pll_b_on_o, pll_c_on_o, pll_b_clk_en_o, pll_c_clk_en_o;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  pll_clkctl_unit i_pll_clkctl_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .lock_i(lock_i), .core_code_o(core_code_o), .core_clk_en_o(core_clk_en_o),
    .code_pending_o(code_pending_o), .code_illegal_o(code_illegal_o),
    .pll_b_fsel_o(pll_b_fsel_o), .pll_b_on_o(pll_b_on_o), .pll_c_on_o(pll_c_on_o),
    .pll_b_clk_en_o(pll_b_clk_en_o), .pll_c_clk_en_o(pll_c_clk_en_o)
  );

  // entry: {wr_data[10:0], exp_rd[10:0], exp_code[5:0], exp_pending, exp_illegal}
  localparam int NV = 8;
  localparam logic [29:0] VEC [NV] = '{
    {11'h025, 11'h025, 6'h24, 1'b1, 1'b0},  // R2 deferred
    {11'h06D, 11'h06D, 6'h2D, 1'b0, 1'b0},  // R3 immediate, top legal code
    {11'h030, 11'h030, 6'h2D, 1'b1, 1'b1},  // R9 deferred reserved
    {11'h07F, 11'h07F, 6'h3F, 1'b0, 1'b1},  // R9 reserved applied
    {11'h023, 11'h023, 6'h3F, 1'b1, 1'b1},  // R9 just below range
    {11'h064, 11'h064, 6'h24, 1'b0, 1'b0},  // R3 bottom legal code
    {11'h128, 11'h128, 6'h24, 1'b1, 1'b0},  // R10 read shows stored code
    {11'h0E6, 11'h0E6, 6'h26, 1'b0, 1'b0}   // R3 with bit 7
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [10:0] d);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    lock_i = '0; rst = 1'b1;
    step(2);
    rst = 1'b0;
    step(1);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    check("R1 rd", rd_data, 11'h024);
    check("R1 code", core_code_o, 6'h24);
    check("R1 flags", {code_pending_o, code_illegal_o}, 0);
    check("R1 gates", {core_clk_en_o, pll_b_clk_en_o, pll_c_clk_en_o}, 0);
    check("R1 enables", {pll_b_fsel_o, pll_b_on_o, pll_c_on_o}, 0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][29:19]);
      check("R10 rd", rd_data, VEC[i][18:8]);
      check("R2/R3 code", core_code_o, VEC[i][7:2]);
      check("R10 pending", code_pending_o, VEC[i][1]);
      check("R9 illegal", code_illegal_o, VEC[i][0]);
    end

    // R11 / R5: rising lock, strict mute
    do_reset();
    wr(11'h02A);
    lock_i[0] = 1'b1;
    step(2);
    check("R5 no valid before 3 edges", core_clk_en_o, 0);
    step(1);
    check("R5 valid after lock", core_clk_en_o, 1);
    check("R11 no copy on rise", core_code_o, 6'h24);
    check("R2 pending", code_pending_o, 1);

    // R4: falling lock copies the buffer
    lock_i[0] = 1'b0;
    step(2);
    check("R4 not yet copied", core_code_o, 6'h24);
    check("R5 still valid", core_clk_en_o, 1);
    step(1);
    check("R4 copied", core_code_o, 6'h2A);
    check("R5 muted", core_clk_en_o, 0);
    check("R4 pending clear", code_pending_o, 0);
    wr(11'h02B);
    step(4);
    check("R4 single copy", core_code_o, 6'h2A);

    // R6: relaxed policy after first lock
    wr(11'h0AA);
    lock_i[0] = 1'b1;
    step(4);
    lock_i[0] = 1'b0;
    step(4);
    check("R6 stays valid after unlock", core_clk_en_o, 1);

    // R6: relaxed policy before first lock
    do_reset();
    wr(11'h0AA);
    step(4);
    check("R6 muted before first lock", core_clk_en_o, 0);
    lock_i[0] = 1'b1;
    step(4);
    check("R6 valid after first lock", core_clk_en_o, 1);

    // R8: second/third PLL enables and gates
    do_reset();
    wr(11'h22A);
    step(3);
    check("R8 b on", pll_b_on_o, 1);
    check("R8 b gated without lock", pll_b_clk_en_o, 0);
    lock_i[1] = 1'b1;
    step(4);
    check("R8 b valid", pll_b_clk_en_o, 1);
    lock_i[2] = 1'b1;
    step(4);
    check("R8 c lock ignored while off", pll_c_clk_en_o, 0);
    wr(11'h62A);
    step(3);
    check("R8 c on", pll_c_on_o, 1);
    check("R8 c valid", pll_c_clk_en_o, 1);
    wr(11'h42A);
    step(3);
    check("R8 b off gated", {pll_b_on_o, pll_b_clk_en_o}, 0);
    check("R8 c unaffected", pll_c_clk_en_o, 1);

    // R7: frequency select passthrough
    wr(11'h12A);
    check("R7 fsel high", pll_b_fsel_o, 1);
    wr(11'h02A);
    check("R7 fsel low", pll_b_fsel_o, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule